// File: doc/BRIEF.md
# I2C GPIO Expander Register Core

This block holds the registers and port logic of a 16-pin, two-port I/O expander that sits behind an I2C or SMBus target front end. The front end does the bit-level protocol and address matching. It reports byte-level events to this block: a transaction start with its direction flag, each received byte, each request for a byte to transmit, and stop. Pins 7:0 form port 0 and pins 15:8 form port 1.

The first byte received in a write transaction is a command byte that loads a register pointer. Each port has four registers: input level, output value, read polarity inversion and direction. A byte written or read moves the pointer to the other port of the same register type. The block drives per-pin output values and output enables, and samples the external pin levels through a two-flop synchronizer.

Top module: `gpx_regcore`

## Requirements
- R1: After reset the output registers read 0xFF, the direction registers read 0xFF, the polarity registers read 0x00, the pointer is 0, `pin_oe` is all zero and `pin_out` is all zero.
- R2: The first byte received after a write start is taken as a command. Codes 0/1 select input port 0/1, 2/3 select output port 0/1, 4/5 select polarity port 0/1, and 6/7 select direction port 0/1.
- R3: After every data byte written or read, pointer bit 0 flips and pointer bits 2:1 stay the same. Consecutive bytes therefore alternate between port 0 and port 1 of one register type.
- R4: An input-port read returns the pin levels, passed through two synchronizer flops and sampled on the read request, whatever the direction of each pin. `tx_data` holds the byte from the clock edge that takes `tx_req`.
- R5: An input-port read returns each pin bit XORed with the matching polarity bit, so a polarity bit of 1 inverts the read bit.
- R6: Data written with the pointer at 0 or 1 changes no register.
- R7: A direction bit of 0 sets the matching `pin_oe` bit to 1 and drives the output register bit on `pin_out`. A direction bit of 1 sets `pin_oe` to 0 and holds `pin_out` at 0.
- R8: An output-port read returns the stored register value, not the pin level.
- R9: A command byte above 7 marks the pointer invalid. While the pointer is invalid, reads return 0xFF and data writes are dropped. The next valid command makes the pointer valid again.
- R10: A read transaction that has no command byte before it uses the pointer left by earlier traffic.
- R11: Received bytes are ignored outside a write transaction, and read requests are ignored outside a read transaction. Stop ends the current transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Transaction start pulse |
| txn_rd | input | 1 | Direction flag with `txn_start`: 1 for read, 0 for write |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_req | input | 1 | Request for the next byte to transmit |
| tx_data | output | 8 | Byte to transmit, valid after the request edge |
| txn_stop | input | 1 | Stop pulse |
| pin_in | input | 16 | Sampled pin levels |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Pin output enables, 1 means driven |

## Verification
Port 0 and port 1 are always given different patterns, such as 0xA5 against 0x3C or 0x55 against 0xAA, so that a pointer that fails to alternate, or a port swap, returns a wrong byte. Direction patterns 0x0F and 0xF0 mix driven and undriven pins, which separates the masking of `pin_out` from the stored output value that reads return. Polarity masks 0xFF and 0x0F set against changing pin levels separate XOR inversion from plain pass-through. Invalid commands, writes at the input pointer, and stray bytes outside a transaction are each followed by reads and port checks that would show any register they changed.

// File: rtl/gpx_regcore.sv
module gpx_regcore (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        txn_start,
  input  logic        txn_rd,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        tx_req,
  output logic [7:0]  tx_data,
  input  logic        txn_stop,
  input  logic [15:0] pin_in,
  output logic [15:0] pin_out,
  output logic [15:0] pin_oe
);

  logic [15:0] sync_a, sync_b;
  logic [1:0][7:0] out_r, pol_r, dir_r;
  logic [2:0] ptr;
  logic       ptr_ok;
  logic       wr_act, rd_act, cmd_pend;
  logic [7:0] rd_mux;

  wire data_wr = rx_valid && wr_act && !cmd_pend;
  wire data_rd = tx_req && rd_act;
  wire [7:0] pin_byte = ptr[0] ? sync_b[15:8] : sync_b[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= pin_in;
      sync_b <= sync_a;
    end
  end

  always_comb begin
    if (!ptr_ok) rd_mux = 8'hFF;
    else begin
      case (ptr[2:1])
        2'd0:    rd_mux = pin_byte ^ pol_r[ptr[0]];
        2'd1:    rd_mux = out_r[ptr[0]];
        2'd2:    rd_mux = pol_r[ptr[0]];
        default: rd_mux = dir_r[ptr[0]];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_r    <= {8'hFF, 8'hFF};
      pol_r    <= '0;
      dir_r    <= {8'hFF, 8'hFF};
      ptr      <= '0;
      ptr_ok   <= 1'b1;
      wr_act   <= 1'b0;
      rd_act   <= 1'b0;
      cmd_pend <= 1'b0;
      tx_data  <= 8'hFF;
    end else if (txn_start) begin
      wr_act   <= !txn_rd;
      rd_act   <= txn_rd;
      cmd_pend <= !txn_rd;
    end else if (txn_stop) begin
      wr_act   <= 1'b0;
      rd_act   <= 1'b0;
      cmd_pend <= 1'b0;
    end else begin
      if (rx_valid && wr_act && cmd_pend) begin
        cmd_pend <= 1'b0;
        if (rx_data < 8'd8) begin
          ptr    <= rx_data[2:0];
          ptr_ok <= 1'b1;
        end else begin
          ptr_ok <= 1'b0;
        end
      end
      if (data_wr) begin
        if (ptr_ok) begin
          case (ptr[2:1])
            2'd1:    out_r[ptr[0]] <= rx_data;
            2'd2:    pol_r[ptr[0]] <= rx_data;
            2'd3:    dir_r[ptr[0]] <= rx_data;
            default: ;
          endcase
        end
        ptr[0] <= ~ptr[0];
      end
      if (data_rd) begin
        tx_data <= rd_mux;
        ptr[0]  <= ~ptr[0];
      end
    end
  end

  assign pin_oe  = ~{dir_r[1], dir_r[0]};
  assign pin_out = {out_r[1], out_r[0]} & pin_oe;

  AST_PTR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!txn_start && !txn_stop && (data_wr || data_rd)) |=>
      (ptr[0] != $past(ptr[0])) && (ptr[2:1] == $past(ptr[2:1]))) else $error("ptr pair"); // R3
  AST_INPUT_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (!txn_start && !txn_stop && data_wr && ptr[2:1] == 2'd0) |=>
      $stable(pin_out) && $stable(pin_oe)) else $error("input write"); // R6
  AST_BAD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (!txn_start && !txn_stop && rx_valid && wr_act && cmd_pend && rx_data > 8'd7) |=> !ptr_ok) else $error("bad cmd"); // R9
  AST_BAD_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!txn_start && !txn_stop && data_rd && !ptr_ok) |=> tx_data == 8'hFF) else $error("bad read"); // R9
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_stop && !txn_start) |=> !wr_act && !rd_act && !cmd_pend) else $error("stop"); // R11
  AST_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !rd_act && !txn_start && !txn_stop) |=> $stable(tx_data)) else $error("stray tx"); // R11

endmodule

// File: tb/gpx_regcore_tb.sv
module gpx_regcore_tb;
  logic clk = 0, rst_n = 0;
  logic txn_start = 0, txn_rd = 0, rx_valid = 0, tx_req = 0, txn_stop = 0;
  logic [7:0] rx_data = 0;
  logic [15:0] pin_in = 16'h3CA5;
  logic [7:0] tx_data;
  logic [15:0] pin_out, pin_oe;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpx_regcore u_dut (.clk, .rst_n, .txn_start, .txn_rd, .rx_valid, .rx_data,
    .tx_req, .tx_data, .txn_stop, .pin_in, .pin_out, .pin_oe);

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic start(input bit rd);
    txn_start = 1; txn_rd = rd; @(negedge clk); txn_start = 0;
  endtask
  task automatic stop();
    txn_stop = 1; @(negedge clk); txn_stop = 0;
  endtask
  task automatic send(input logic [7:0] b);
    rx_valid = 1; rx_data = b; @(negedge clk); rx_valid = 0;
  endtask
  task automatic rd(input logic [7:0] exp, input string tag);
    tx_req = 1; @(negedge clk); tx_req = 0;
    chk(tx_data == exp, tag, {8'h0, tx_data}, {8'h0, exp});
  endtask
  task automatic wr2(input logic [7:0] cmd, input logic [7:0] b0, input logic [7:0] b1);
    start(0); send(cmd); send(b0); send(b1); stop();
  endtask
  task automatic point(input logic [7:0] cmd);
    start(0); send(cmd); stop();
  endtask
  task automatic setpins(input logic [15:0] p);
    pin_in = p; repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(pin_oe == 16'h0, "R1 oe", pin_oe, 16'h0);
    chk(pin_out == 16'h0, "R1 out", pin_out, 16'h0);
    start(1); rd(8'hA5, "R10 R4 port0"); rd(8'h3C, "R4 port1"); stop();
    point(2); start(1); rd(8'hFF, "R1 out0"); rd(8'hFF, "R1 out1"); stop();
    point(4); start(1); rd(8'h00, "R1 pol0"); rd(8'h00, "R1 pol1"); stop();
    point(6); start(1); rd(8'hFF, "R1 dir0"); rd(8'hFF, "R1 dir1"); stop();
  endtask

  task automatic t_dir_out();
    wr2(8'd6, 8'h0F, 8'hF0);
    wr2(8'd2, 8'h55, 8'hAA);
    chk(pin_oe == 16'h0FF0, "R7 R2 oe", pin_oe, 16'h0FF0);
    chk(pin_out == 16'h0A50, "R7 out", pin_out, 16'h0A50);
    point(3);
    start(1); rd(8'hAA, "R8 R2 out1"); rd(8'h55, "R3 out0"); rd(8'hAA, "R3 out1 again"); stop();
  endtask

  task automatic t_polarity();
    wr2(8'd4, 8'hFF, 8'h0F);
    point(0);
    start(1); rd(8'h5A, "R5 inv0"); rd(8'h33, "R5 inv1"); stop();
    setpins(16'h00F0);
    point(0);
    start(1); rd(8'h0F, "R4 R5 new0"); rd(8'h0F, "R4 R5 new1"); stop();
  endtask

  task automatic t_input_ro();
    wr2(8'd0, 8'h12, 8'h34);
    wr2(8'd1, 8'h12, 8'h34);
    chk(pin_oe == 16'h0FF0, "R6 oe", pin_oe, 16'h0FF0);
    chk(pin_out == 16'h0A50, "R6 out", pin_out, 16'h0A50);
    point(4);
    start(1); rd(8'hFF, "R6 pol0"); rd(8'h0F, "R6 pol1"); stop();
  endtask

  task automatic t_bad_cmd();
    wr2(8'h09, 8'h77, 8'h66);
    start(1); rd(8'hFF, "R9 rd"); rd(8'hFF, "R9 rd2"); stop();
    chk(pin_oe == 16'h0FF0, "R9 oe", pin_oe, 16'h0FF0);
    chk(pin_out == 16'h0A50, "R9 out", pin_out, 16'h0A50);
    point(2);
    start(1); rd(8'h55, "R9 recover"); stop();
  endtask

  task automatic t_stray();
    point(6);
    start(1); send(8'h02); send(8'h00); rd(8'h0F, "R11 rx in read"); stop();
    send(8'h00); send(8'h00);
    chk(pin_oe == 16'h0FF0, "R11 idle rx", pin_oe, 16'h0FF0);
    start(0); send(8'd2); tx_req = 1; @(negedge clk); tx_req = 0;
    chk(tx_data == 8'h0F, "R11 tx in write", {8'h0, tx_data}, 16'h000F);
    send(8'h11); stop();
    chk(pin_out == 16'h0A10, "R11 write after stray", pin_out, 16'h0A10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_dir_out();
    t_polarity();
    t_input_ro();
    t_bad_cmd();
    t_stray();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule